// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block drives the system reset from three causes: a supply that has not yet stayed good long enough after power-up, a supply that falls below its trip level, and a watchdog that was not serviced in time. The two supply comparators reach it as digital levels that are synchronous to the clock. Time is counted in units of a one-cycle tick input, which is nominally one millisecond, so each period and the holdoff are counted in ticks.

The watchdog is serviced only by activity on the two-wire serial bus. A start condition, which is SDA falling while SCL is high, clears its count. Both bus lines pass through two synchronizing flops before the start condition is decoded. A 2-bit select, taken from a control register, picks one of three periods or turns the watchdog off. Every reset, whatever its cause, lasts at least the holdoff time measured with the supply good. The reset appears as an active-low output, an active-high output, and a flag that nearby logic uses to abort and refuse bus transfers.

Top module: `sup_reset_gen`

## Requirements
- R1: After `por_n` is released with the supply good, reset stays asserted through HOLD_TICKS-1 ticks. It is released on the tick numbered HOLD_TICKS.
- R2: When `vcc_ok` is low, reset is asserted in the same cycle and ticks do not advance the holdoff. Once `vcc_ok` returns, a full HOLD_TICKS of good supply is needed before release, and any dip restarts that count.
- R3: When `vcc_valid` is low, reset is asserted whatever the level of `vcc_ok`. It is released only after HOLD_TICKS ticks with both inputs high.
- R4: The watchdog period, in ticks, is set by `wd_sel`: 2'b00 selects WD_LONG, 2'b01 selects WD_MID and 2'b10 selects WD_SHORT. If no start condition arrives, reset asserts on the tick that completes the selected period.
- R5: With `wd_sel` = 2'b11 the watchdog is off, and no number of ticks causes a reset.
- R6: A start condition (SDA falling while SCL is high) clears the watchdog count. An SDA fall while SCL is low does not clear it.
- R7: A reset caused by a watchdog timeout is held for HOLD_TICKS ticks and is then released.
- R8: The watchdog count is held at zero while reset is active, so after any release a full period is needed before the next timeout.
- R9: `reset_active` and `rst_out` are always equal, and `rst_out_n` is always their complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on clear, active low; reset is asserted while it is low |
| tick | input | 1 | One-cycle timebase pulse |
| vcc_ok | input | 1 | High while the supply is above the trip level |
| vcc_valid | input | 1 | High while the supply is high enough for defined operation |
| wd_sel | input | 2 | Watchdog period select, where 2'b11 turns the watchdog off |
| sda_in | input | 1 | Serial data line, asynchronous |
| scl_in | input | 1 | Serial clock line, asynchronous |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |
| reset_active | output | 1 | Reset flag used to abort and block bus transfers |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that `vcc_ok` and `vcc_valid` are already synchronous to `clk`. They also assume that the bus lines hold each level for several clocks, so that the synchronizer sees every edge. The bench drives every input on the falling clock edge, pulses `tick` for exactly one cycle, and holds SDA and SCL for four clocks around each transition. It changes `wd_sel` only between tick pulses, and only while the count is known, either just after a start condition or while reset is active.

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int WD_LONG    = 1400,
  parameter int WD_MID     = 600,
  parameter int WD_SHORT   = 200,
  parameter int HOLD_TICKS = 250
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       vcc_ok,
  input  logic       vcc_valid,
  input  logic [1:0] wd_sel,
  input  logic       sda_in,
  input  logic       scl_in,
  output logic       rst_out_n,
  output logic       rst_out,
  output logic       reset_active
);
  localparam int WD_TOP = (WD_LONG > WD_MID) ? ((WD_LONG > WD_SHORT) ? WD_LONG : WD_SHORT)
                                             : ((WD_MID > WD_SHORT) ? WD_MID : WD_SHORT);
  localparam int CW = $clog2(WD_TOP + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [2:0]    sda_sr, scl_sr;
  logic          start_det, supply_bad, wd_on, wd_fire, rst_q;
  logic [CW-1:0] wd_cnt, wd_last;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sda_sr <= '1;
      scl_sr <= '1;
    end else begin
      sda_sr <= {sda_sr[1:0], sda_in};
      scl_sr <= {scl_sr[1:0], scl_in};
    end

  assign start_det  = sda_sr[2] & ~sda_sr[1] & scl_sr[2] & scl_sr[1];
  assign supply_bad = ~vcc_ok | ~vcc_valid;

  always_comb
    case (wd_sel)
      2'b00:   wd_last = CW'(WD_LONG - 1);
      2'b01:   wd_last = CW'(WD_MID - 1);
      default: wd_last = CW'(WD_SHORT - 1);
    endcase

  assign wd_on   = (wd_sel != 2'b11);
  assign wd_fire = wd_on & ~reset_active & tick & (wd_cnt >= wd_last);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (supply_bad || wd_fire) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q && tick) begin
      if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)
      wd_cnt <= '0;
    else if (reset_active || !wd_on || start_det || wd_fire)
      wd_cnt <= '0;
    else if (tick)
      wd_cnt <= wd_cnt + 1'b1;

  assign reset_active = rst_q | supply_bad;
  assign rst_out      = reset_active;
  assign rst_out_n    = ~reset_active;

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> $past(tick) && $past(vcc_ok) && $past(vcc_valid)); // R1
  AST_BAD_SUPPLY_RESTART: assert property (@(posedge clk) disable iff (!por_n)
    supply_bad |=> rst_q && hold_cnt == '0); // R2
  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !vcc_valid |-> rst_out && !rst_out_n); // R3
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_q) |-> $past(supply_bad) || ($past(tick) && $past(wd_sel) != 2'b11)); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    wd_sel == 2'b11 |=> wd_cnt == '0); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    start_det |=> wd_cnt == '0); // R6
  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!por_n)
    hold_cnt < HW'(HOLD_TICKS)); // R7
  AST_WD_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    reset_active |=> wd_cnt == '0); // R8
  AST_POLARITY: assert property (@(posedge clk) disable iff (!por_n)
    rst_out_n != rst_out); // R9
endmodule

// File: tb/sup_reset_gen_tb.sv
module sup_reset_gen_tb_top;
  localparam int LONG = 14, MID = 6, SHORT = 3, HOLD = 5;

  logic clk = 1'b0, por_n = 1'b0, tick = 1'b0, vcc_ok = 1'b1, vcc_valid = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic sda = 1'b1, scl = 1'b1;
  logic rst_out_n, rst_out, reset_active;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sup_reset_gen #(.WD_LONG(LONG), .WD_MID(MID), .WD_SHORT(SHORT), .HOLD_TICKS(HOLD)) dut_i (
    .clk(clk), .por_n(por_n), .tick(tick), .vcc_ok(vcc_ok), .vcc_valid(vcc_valid),
    .wd_sel(wd_sel), .sda_in(sda), .scl_in(scl),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .reset_active(reset_active));

  task automatic check(input bit exp, input string tag);
    n_chk++;
    if (rst_out !== exp || reset_active !== exp || rst_out_n !== ~exp) begin
      n_bad++;
      $display("FAIL %s: rst_out=%b reset_active=%b rst_out_n=%b expected active=%b",
               tag, rst_out, reset_active, rst_out_n, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_fall(input bit scl_level);
    @(negedge clk) begin scl = scl_level; sda = 1'b1; end
    wait_clk(4);
    sda = 1'b0;
    wait_clk(4);
    scl = 1'b0;
    wait_clk(4);
    sda = 1'b1;
    wait_clk(4);
    scl = 1'b1;
    wait_clk(4);
  endtask

  task automatic recover(input string tag);
    ticks(HOLD - 1);
    check(1'b1, {tag, " still held"});
    ticks(1);
    check(1'b0, {tag, " released"});
  endtask

  task automatic t_power_up;
    wd_sel = 2'b11;
    wait_clk(3);
    check(1'b1, "R1 active during por");
    @(negedge clk) por_n = 1'b1;
    wait_clk(2);
    check(1'b1, "R1 active after por");
    recover("R1 holdoff");
  endtask

  task automatic t_disabled;
    wd_sel = 2'b11;
    ticks(LONG + 6);
    check(1'b0, "R5 disabled watchdog never fires");
  endtask

  task automatic t_period(input logic [1:0] sel, input int n, input string tag);
    wd_sel = sel;
    bus_fall(1'b1);
    ticks(n - 1);
    check(1'b0, {tag, " before period"});
    ticks(1);
    check(1'b1, {tag, " timeout at period"});
    recover("R7 timeout reset");
    ticks(n - 1);
    check(1'b0, "R8 count restarted from zero");
    ticks(1);
    check(1'b1, "R8 full period after release");
    recover("R7 second timeout");
  endtask

  task automatic t_kick;
    wd_sel = 2'b01;
    bus_fall(1'b1);
    ticks(MID - 2);
    bus_fall(1'b1);
    ticks(MID - 2);
    check(1'b0, "R6 start restarts count");
    bus_fall(1'b1);
    ticks(MID - 1);
    bus_fall(1'b0);
    ticks(1);
    check(1'b1, "R6 sda fall with scl low ignored");
    recover("R6 recover");
    wd_sel = 2'b11;
  endtask

  task automatic t_supply;
    wd_sel = 2'b11;
    @(negedge clk) vcc_ok = 1'b0;
    #1 check(1'b1, "R2 immediate assert");
    ticks(HOLD + 3);
    check(1'b1, "R2 held while low");
    @(negedge clk) vcc_ok = 1'b1;
    ticks(HOLD - 1);
    @(negedge clk) vcc_ok = 1'b0;
    @(negedge clk) vcc_ok = 1'b1;
    ticks(HOLD - 1);
    check(1'b1, "R2 dip restarts holdoff");
    ticks(1);
    check(1'b0, "R2 released after full holdoff");
  endtask

  task automatic t_valid;
    @(negedge clk) vcc_valid = 1'b0;
    #1 check(1'b1, "R3 invalid supply asserts");
    ticks(HOLD + 2);
    check(1'b1, "R3 held while invalid");
    @(negedge clk) vcc_valid = 1'b1;
    recover("R3 recover");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run still going at cycle %0d, expected end", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_power_up();
    t_disabled();
    t_period(2'b00, LONG, "R4 long");
    t_period(2'b01, MID, "R4 mid");
    t_period(2'b10, SHORT, "R4 short");
    t_kick();
    t_supply();
    t_valid();
    t_disabled();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule